// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Engine

This block moves one byte at a time over a four-wire synchronous serial link. A single configuration input picks the role. As master it generates the serial clock from the system clock and starts transfers. As slave it follows a clock and a select line from outside. In both roles it sends eight bits MSB first and receives eight bits in the same pass. Clock polarity and phase are programmable, so all four SPI modes are available. The master bit rate is the system clock divided by any even number from 2 to 256.

The parallel side is a write strobe with a transmit byte, a received-byte output, a `busy` level and a one-cycle `done` pulse. The slave-select line is always an input, in both roles. As master, the engine runs only while that line is high. Pulling it low blocks a start and aborts a transfer that is already running. As slave, the engine shifts only while the line is low. The slave's clock, select and data inputs pass through a two-flop synchroniser. Each pad has an enable output, so the pad ring can build the tri-state buffers.

The controller has five states. `ST_IDLE` moves to `ST_M_LEAD` on a master start (write strobe with select high), or to `ST_S_SHIFT` when a slave sees select go low. `ST_M_LEAD` goes to `ST_M_TRAIL` at the end of a half period. `ST_M_TRAIL` goes back to `ST_M_LEAD` for the next bit, or to `ST_IDLE` after the eighth bit. Both master states drop to `ST_IDLE` when select goes low. `ST_S_SHIFT` goes to `ST_S_HOLD` on the eighth sampling edge, or to `ST_IDLE` if select rises first. `ST_S_HOLD` waits for select to rise and then returns to `ST_IDLE`.

Top module: `spi_xfer_engine`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `done` and `rx_byte` are 0, `sck_out` equals `cfg_cpol`, and `miso_oe` is 0 in master role.
- R2: In master role with synchronised select high, a write in `ST_IDLE` raises `busy` on the next cycle and runs one full-duplex transfer. `mosi_out` carries `tx_byte` MSB first, and `rx_byte` ends up holding the eight `miso_in` bits MSB first. `done` then pulses once, with `busy` low in that cycle.
- R3: With `cfg_div` = D (0..127), the divisor is 2·(D+1). Each serial clock half period lasts D+1 system cycles, and `done` is high exactly 16·(D+1) clock edges after the edge that accepted the write.
- R4: `cfg_cpol` sets the idle level of the serial clock. With `cfg_cpha` = 0, data is valid before the first edge and is sampled on the leading edge. With `cfg_cpha` = 1, data is driven on the leading edge and sampled on the trailing edge. This holds in both roles.
- R5: In master role, `sck_out` sits at `cfg_cpol` whenever `busy` is low, including between back-to-back bytes.
- R6: In master role, synchronised select low blocks a start. If select falls during a transfer, the engine returns to `ST_IDLE` with no `done`, `rx_byte` unchanged, and `sck_out` at idle.
- R7: In slave role, select low starts a transfer. The slave returns its held transmit byte MSB first on `miso_out` and captures `mosi_in` MSB first. After the eighth sampling edge it updates `rx_byte` and pulses `done`.
- R8: Pad enables follow the role. Master: `sck_oe` = 1, `mosi_oe` = 1, `miso_oe` = 0. Slave: `sck_oe` = 0, `mosi_oe` = 0, and `miso_oe` = 1 only while synchronised select is low.
- R9: A write while `busy` is high has no effect. A master keeps the byte in flight. A slave keeps its held transmit byte for the next transfer.
- R10: In slave role, if select rises before eight bits have been sampled, the transfer is dropped: no `done`, `rx_byte` unchanged, `busy` low.
- R11: `done` never lasts more than one cycle, and `rx_byte` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 selects master role, 0 selects slave role |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_div | input | 7 | Master divisor code D; divisor is 2·(D+1) |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_byte | input | 8 | Byte to transmit |
| rx_byte | output | 8 | Last completely received byte |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a byte completes |
| ss_n_in | input | 1 | Slave-select line, input in both roles |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Output enable for the serial clock pad |
| mosi_in | input | 1 | Master-to-slave data as seen in slave role |
| mosi_out | output | 1 | Master-to-slave data driven in master role |
| mosi_oe | output | 1 | Output enable for the master-to-slave pad |
| miso_in | input | 1 | Slave-to-master data as seen in master role |
| miso_out | output | 1 | Slave-to-master data driven in slave role |
| miso_oe | output | 1 | Output enable for the slave-to-master pad |

## Verification
The assertions take three things for granted. The configuration inputs do not change while `busy` is high. Select is deasserted before the role is switched. In slave role, each external clock half period is longer than the three-cycle synchroniser and edge-detect delay. The stimulus changes configuration only in `ST_IDLE` and parks `ss_n_in` high around every role switch. It holds each external clock level for six system cycles and moves `mosi_in` only away from the sampling edges. As master, the bench's own slave model reacts to `sck_out` on falling clock edges. This keeps `miso_in` stable over the cycle in which the engine samples it.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_M_LEAD  = 3'd1,
        ST_M_TRAIL = 3'd2,
        ST_S_SHIFT = 3'd3,
        ST_S_HOLD  = 3'd4
    } eng_state_t;
endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
module spi_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_half_timer.sv
// Counts system cycles inside one serial clock half period.
module spi_half_timer #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_sel,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_shifter.sv
// MSB-first shift register shared by both roles.
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], shift_in};
    end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              busy,
    output logic              done,
    input  logic              ss_n_in,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe
);
    localparam int                CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);

    eng_state_t state, state_nx;

    // synchronised serial inputs: {select, clock, data}
    logic [2:0] sync_q;
    logic       ss_s, sck_s, mosi_s, sck_prev;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_in, sck_in, mosi_in}),
        .q     (sync_q)
    );
    assign ss_s   = sync_q[2];
    assign sck_s  = sync_q[1];
    assign mosi_s = sync_q[0];

    // slave edge classification
    logic sck_edge, lead_edge, trail_edge, smp_edge, sft_edge;
    assign sck_edge   = (sck_s != sck_prev);
    assign lead_edge  = sck_edge && (sck_s != cfg_cpol);
    assign trail_edge = sck_edge && (sck_s == cfg_cpol);
    assign smp_edge   = cfg_cpha ? trail_edge : lead_edge;
    assign sft_edge   = cfg_cpha ? lead_edge  : trail_edge;

    // master half-period timer
    logic tick, timer_run;
    assign timer_run = (state == ST_M_LEAD) || (state == ST_M_TRAIL);

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .half_sel (cfg_div),
        .tick     (tick)
    );

    // datapath control
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] tx_hold, sr_q;
    logic              cap, last;
    logic              m_start, s_start, m_sample, m_bit_end, m_finish;
    logic              s_sample, s_shift, sh_load, sh_shift, hold_we;

    assign last      = (bit_cnt == LAST_BIT);
    assign m_start   = (state == ST_IDLE) && cfg_master && tx_we && ss_s;
    assign s_start   = (state == ST_IDLE) && !cfg_master && !ss_s;
    assign m_sample  = (state == ST_M_LEAD) && tick && ss_s;
    assign m_bit_end = (state == ST_M_TRAIL) && tick && ss_s;
    assign m_finish  = m_bit_end && last;
    assign s_sample  = (state == ST_S_SHIFT) && !ss_s && smp_edge;
    assign s_shift   = (state == ST_S_SHIFT) && !ss_s && sft_edge && (bit_cnt != '0);
    assign sh_load   = m_start || s_start;
    assign sh_shift  = (m_bit_end && !last) || s_shift;
    assign hold_we   = !cfg_master && tx_we &&
                       ((state == ST_IDLE) || (state == ST_S_HOLD));

    spi_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (cfg_master ? tx_byte : tx_hold),
        .shift    (sh_shift),
        .shift_in (cap),
        .q        (sr_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (m_start)      state_nx = ST_M_LEAD;
                else if (s_start) state_nx = ST_S_SHIFT;
            end
            ST_M_LEAD: begin
                if (!ss_s)     state_nx = ST_IDLE;
                else if (tick) state_nx = ST_M_TRAIL;
            end
            ST_M_TRAIL: begin
                if (!ss_s)     state_nx = ST_IDLE;
                else if (tick) state_nx = last ? ST_IDLE : ST_M_LEAD;
            end
            ST_S_SHIFT: begin
                if (ss_s)                  state_nx = ST_IDLE;
                else if (s_sample && last) state_nx = ST_S_HOLD;
            end
            ST_S_HOLD: begin
                if (ss_s) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            cap      <= 1'b0;
            rx_byte  <= '0;
            done     <= 1'b0;
            tx_hold  <= '0;
            sck_prev <= 1'b0;
        end else begin
            done     <= 1'b0;
            sck_prev <= sck_s;
            if (sh_load)   bit_cnt <= '0;
            if (m_sample)  cap <= miso_in;
            if (m_bit_end) bit_cnt <= bit_cnt + 1'b1;
            if (m_finish) begin
                rx_byte <= {sr_q[DATA_W-2:0], cap};
                done    <= 1'b1;
            end
            if (s_sample) begin
                cap     <= mosi_s;
                bit_cnt <= bit_cnt + 1'b1;
                if (last) begin
                    rx_byte <= {sr_q[DATA_W-2:0], mosi_s};
                    done    <= 1'b1;
                end
            end
            if (hold_we) tx_hold <= tx_byte;
        end
    end

    // outputs
    always_comb begin
        busy     = (state == ST_M_LEAD) || (state == ST_M_TRAIL) || (state == ST_S_SHIFT);
        unique case (state)
            ST_M_LEAD:  sck_out = cfg_cpol ^ cfg_cpha;
            ST_M_TRAIL: sck_out = cfg_cpol ^ ~cfg_cpha;
            default:    sck_out = cfg_cpol;
        endcase
        sck_oe   = cfg_master;
        mosi_out = sr_q[DATA_W-1];
        mosi_oe  = cfg_master;
        miso_out = sr_q[DATA_W-1];
        miso_oe  = !cfg_master && !ss_s;
    end
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_master,
    input logic              cfg_cpol,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rx_byte,
    input logic              sck_out,
    input logic              miso_oe,
    input logic              ss_s
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !busy) |-> (sck_out == cfg_cpol));

    // R6
    ss_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master ? !ss_s : ss_s) |=> !busy);

    // R8
    miso_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (!cfg_master && !ss_s));
endmodule

bind spi_xfer_engine spi_eng_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .cfg_cpol   (cfg_cpol),
    .busy       (busy),
    .done       (done),
    .rx_byte    (rx_byte),
    .sck_out    (sck_out),
    .miso_oe    (miso_oe),
    .ss_s       (ss_s)
);

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;
    localparam int HB = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_master, cfg_cpol, cfg_cpha;
    logic [6:0] cfg_div;
    logic       tx_we;
    logic [7:0] tx_byte, rx_byte;
    logic       busy, done;
    logic       ss_n_in, sck_in, sck_out, sck_oe;
    logic       mosi_in, mosi_out, mosi_oe;
    logic       miso_in, miso_out, miso_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    spi_xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .tx_we(tx_we), .tx_byte(tx_byte),
        .rx_byte(rx_byte), .busy(busy), .done(done), .ss_n_in(ss_n_in),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .mosi_in(mosi_in),
        .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_in(miso_in),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    // master-role vectors: {cpol, cpha, div, master byte, slave reply}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 1'b0, 7'd0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 7'd1, 8'h96, 8'hC3},
        {1'b1, 1'b0, 7'd2, 8'h01, 8'h80},
        {1'b1, 1'b1, 7'd0, 8'hFF, 8'h00},
        {1'b0, 1'b0, 7'd3, 8'h7E, 8'hE7},
        {1'b1, 1'b1, 7'd1, 8'h00, 8'hFF}
    };

    always @(negedge clk) if (rst_n && done) done_cnt++;

    // behavioural slave used while the engine is master
    logic       bs_arm;
    logic [7:0] bs_tx, bs_cap;
    int         bs_outs;
    logic       bs_prev, bs_lead;
    always @(negedge clk) begin
        if (!bs_arm) begin
            bs_prev = cfg_cpol;
            bs_cap  = 8'h00;
            bs_outs = cfg_cpha ? 0 : 1;
            miso_in = cfg_cpha ? 1'b0 : bs_tx[7];
        end else if (sck_out != bs_prev) begin
            bs_lead = (sck_out != cfg_cpol);
            if (bs_lead != cfg_cpha) bs_cap = {bs_cap[6:0], mosi_out};
            else if (bs_outs < 8) begin
                miso_in = bs_tx[7 - bs_outs];
                bs_outs++;
            end
            bs_prev = sck_out;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_master(input logic pol, input logic pha, input logic [6:0] dv,
                              input logic [7:0] mtx, input logic [7:0] rep, input bit poke);
        int m;
        int d0;
        cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv; bs_tx = rep; bs_arm = 1'b0;
        repeat (3) @(negedge clk);
        bs_arm = 1'b1;
        d0 = done_cnt;
        tx_byte = mtx; tx_we = 1'b1;
        m = 0;
        do begin
            @(negedge clk);
            m++;
            if (m == 1) begin
                tx_we = 1'b0;
                chk("R2 busy after start", busy, 1);
            end
            if (poke && m == 5) begin tx_we = 1'b1; tx_byte = ~mtx; end
            if (poke && m == 6) tx_we = 1'b0;
        end while (!done && m < 6000);
        chk("R3 cycles to done", m - 1, 16 * (dv + 1));
        chk("R2 R4 master rx_byte", rx_byte, rep);
        chk(poke ? "R9 byte in flight kept" : "R2 R4 mosi stream", bs_cap, mtx);
        chk("R5 sck at idle after byte", sck_out, pol);
        @(negedge clk);
        chk("R11 done single cycle", done, 0);
        @(negedge clk);
        chk("R2 one done pulse", done_cnt - d0, 1);
    endtask

    task automatic run_slave(input logic pol, input logic pha, input bit wr,
                             input logic [7:0] hold, input logic [7:0] mb,
                             input int stop_at, input bit poke, output logic [7:0] got);
        got = 8'h00;
        cfg_cpol = pol; cfg_cpha = pha; sck_in = pol; mosi_in = 1'b0;
        repeat (4) @(negedge clk);
        if (wr) begin
            tx_byte = hold; tx_we = 1'b1;
            @(negedge clk);
            tx_we = 1'b0;
        end
        chk("R8 miso released while deselected", miso_oe, 0);
        ss_n_in = 1'b0;
        repeat (HB) @(negedge clk);
        chk("R8 miso driven while selected", miso_oe, 1);
        for (int i = 0; i < 8; i++) begin
            if (i < stop_at) begin
                if (poke && i == 3) begin
                    tx_byte = 8'hEE; tx_we = 1'b1;
                    @(negedge clk);
                    tx_we = 1'b0;
                end
                if (!pha) begin
                    mosi_in = mb[7 - i];
                    repeat (HB) @(negedge clk);
                    got = {got[6:0], miso_out};
                    sck_in = ~pol;
                    repeat (HB) @(negedge clk);
                    sck_in = pol;
                end else begin
                    sck_in = ~pol;
                    mosi_in = mb[7 - i];
                    repeat (HB) @(negedge clk);
                    got = {got[6:0], miso_out};
                    sck_in = pol;
                    repeat (HB) @(negedge clk);
                end
            end
        end
        repeat (HB) @(negedge clk);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    logic [7:0] got, hb, mbv, rx_prev;
    int         d0;

    initial begin
        rst_n = 1'b0; cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 7'd0;
        tx_we = 1'b0; tx_byte = 8'h00; ss_n_in = 1'b1; sck_in = 1'b0; mosi_in = 1'b0;
        bs_arm = 1'b0; bs_tx = 8'h00;
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 rx_byte in reset", rx_byte, 0);
        chk("R1 miso_oe in reset", miso_oe, 0);
        cfg_cpol = 1'b1;
        @(negedge clk);
        chk("R1 sck idle follows polarity", sck_out, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 rx_byte after reset", rx_byte, 0);
        chk("R8 master sck_oe", sck_oe, 1);
        chk("R8 master mosi_oe", mosi_oe, 1);
        chk("R8 master miso_oe", miso_oe, 0);

        // vector table, master role
        for (int v = 0; v < 6; v++) begin
            run_master(VEC[v][24], VEC[v][23], VEC[v][22:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
        end

        // R9: write during a master transfer
        run_master(1'b0, 1'b1, 7'd1, 8'h5A, 8'hA5, 1'b1);

        // R6: select low blocks a start
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        d0 = done_cnt;
        tx_byte = 8'h33; tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
        chk("R6 no start with select low", busy, 0);
        repeat (6) @(negedge clk);
        chk("R6 still idle", busy, 0);
        chk("R6 no done when blocked", done_cnt - d0, 0);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);

        // R6: select falls mid-transfer
        cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_div = 7'd3; bs_tx = 8'h11; bs_arm = 1'b0;
        repeat (3) @(negedge clk);
        bs_arm = 1'b1;
        rx_prev = rx_byte;
        d0 = done_cnt;
        tx_byte = 8'hC0; tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
        repeat (20) @(negedge clk);
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 abort clears busy", busy, 0);
        chk("R6 abort sck idle", sck_out, 1);
        repeat (2) @(negedge clk);
        chk("R6 abort no done", done_cnt - d0, 0);
        chk("R6 abort rx kept", rx_byte, rx_prev);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);

        // slave role
        bs_arm = 1'b0;
        cfg_master = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 slave sck_oe", sck_oe, 0);
        chk("R8 slave mosi_oe", mosi_oe, 0);
        for (int m = 0; m < 4; m++) begin
            hb  = 8'(8'hC5 + m * 17);
            mbv = 8'(8'h29 ^ (m * 16));
            d0  = done_cnt;
            run_slave(m[1], m[0], 1'b1, hb, mbv, 8, 1'b0, got);
            chk("R7 R4 slave miso stream", got, hb);
            chk("R7 R4 slave rx_byte", rx_byte, mbv);
            chk("R7 one done pulse", done_cnt - d0, 1);
        end

        // R9: write during a slave transfer leaves the held byte
        run_slave(1'b0, 1'b0, 1'b1, 8'h6B, 8'h14, 8, 1'b1, got);
        chk("R9 slave first transfer", got, 8'h6B);
        run_slave(1'b0, 1'b0, 1'b0, 8'h00, 8'h99, 8, 1'b0, got);
        chk("R9 slave held byte kept", got, 8'h6B);

        // R10: select rises after four bits
        rx_prev = rx_byte;
        d0 = done_cnt;
        run_slave(1'b1, 1'b0, 1'b1, 8'hF0, 8'h0F, 4, 1'b0, got);
        chk("R10 no done on short frame", done_cnt - d0, 0);
        chk("R10 rx kept on short frame", rx_byte, rx_prev);
        chk("R10 busy cleared", busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule